// File: doc/BRIEF.md
# Host-State Validity Checker for Virtual-Machine Entry

This block judges whether a saved set of host-state values is fit to be restored when a virtual machine later exits. It receives a snapshot of seven 16-bit segment selectors, five 64-bit base addresses, the 32-bit exit-control word and a flag saying whether the processor is currently running in long (64-bit) mode. A single-cycle start pulse captures the snapshot. Two clock edges later the block presents a done flag, a pass flag, an error number and a 16-bit map with one bit per broken rule. The entry sequencer uses the error number to abort an entry, and debug logic reads the map.

There are two kinds of failure. The exit-control word can disagree with the current execution mode; this is a control fault and reports error number 7. The host state itself can be malformed, through bad selector flags, a null selector where one is forbidden, or a non-canonical base; this is a host-state fault and reports error number 8. The hardware gives these checks no fixed order, so the block picks one to keep its results deterministic: a control fault always wins. The map still lists every broken rule, of either kind.

Top module: `hsv_entry_check`

## Requirements
- R1: For each selector (packed in `sel_i` at slot index 0=CS, 1=SS, 2=DS, 3=ES, 4=FS, 5=GS, 6=TR, 16 bits per slot), a nonzero value in bits 2:0 sets violation bit equal to the slot index (bits 6:0).
- R2: A CS selector of 0x0000 sets violation bit 7, and a TR selector of 0x0000 sets violation bit 8.
- R3: An SS selector of 0x0000 sets violation bit 9 only when bit 9 of `exit_ctl_i` (return-to-64-bit control) is 0. When that bit is 1, a null SS has no effect on the map, the error number or pass.
- R4: Each base (packed in `base_i` at slot 0=FS, 1=GS, 2=TR, 3=GDTR, 4=IDTR, 64 bits per slot) whose bits 63:47 are not all equal sets violation bit 10 plus the slot index (bits 14:10).
- R5: When `long_mode_i` is 1 and bit 9 of `exit_ctl_i` is 0, violation bit 15 is set.
- R6: When bit 15 is set, the error number is 7, whatever host-state bits are also set.
- R7: With bit 15 clear, any set bit in 14:0 gives error number 8, and an empty map gives error number 0. Pass is 1 exactly when the error number is 0.
- R8: Inputs are sampled at the clock edge where `start_i` is high. Done is low after that edge and high after the next one, when the results appear. Later input changes have no effect, and all outputs hold until the next start.
- R9: Synchronous active-high reset clears done, pass, the error number and the violation map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to evaluate the snapshot |
| sel_i | input | 112 | Seven 16-bit selectors, slot 0 in the low bits |
| base_i | input | 320 | Five 64-bit base addresses, slot 0 in the low bits |
| exit_ctl_i | input | 32 | Exit-control word; bit 9 selects return to 64-bit mode |
| long_mode_i | input | 1 | Processor is in long mode at entry |
| done_o | output | 1 | Results valid |
| pass_o | output | 1 | No rule broken |
| err_o | output | 8 | Error number: 0, 7 or 8 |
| viol_o | output | 16 | One bit per broken rule |

## Verification
The control-versus-host priority and the host-state rules are both evaluated in the same cycle from one snapshot, so the case that matters is a control fault together with one or more host faults. The bench creates it on purpose: long mode on with the 64-bit exit control off, combined with bad selector flags or a non-canonical base. It also mixes the two through random snapshots. In each such case the error number must be 7 while the map still shows every host-state bit next to bit 15. A second overlap, between a new result landing and held outputs, is covered by changing the inputs right after sampling and checking that the outputs stay stable between starts.

// File: rtl/hsv_pkg.sv
package hsv_pkg;
  // violation map layout
  localparam int VB_NULL_CS = 7;
  localparam int VB_NULL_TR = 8;
  localparam int VB_NULL_SS = 9;
  localparam int VB_CANON0  = 10;
  localparam int VB_LMODE   = 15;
  localparam int VIOL_BITS  = 16;

  // selector slots
  localparam int SLOT_CS = 0;
  localparam int SLOT_SS = 1;
  localparam int SLOT_TR = 6;

  localparam logic [7:0] CODE_NONE = 8'd0;
  localparam logic [7:0] CODE_CTL  = 8'd7;
  localparam logic [7:0] CODE_HOST = 8'd8;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HOST = 2'd1,
    CLS_CTL  = 2'd2
  } err_class_e;
endpackage

// File: rtl/hsv_sel_check.sv
module hsv_sel_check #(
  parameter int SEL_W   = 16,
  parameter int NUM_SEG = 7,
  parameter int FLAG_W  = 3
) (
  input  logic [NUM_SEG*SEL_W-1:0] sel,
  input  logic                     host64,
  output logic [NUM_SEG-1:0]       flag_bad,
  output logic                     cs_null,
  output logic                     tr_null,
  output logic                     ss_null
);
  import hsv_pkg::*;

  logic [NUM_SEG-1:0] is_null;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign flag_bad[g] = |sel[g*SEL_W +: FLAG_W];
    assign is_null[g]  = (sel[g*SEL_W +: SEL_W] == '0);
  end

  assign cs_null = is_null[SLOT_CS];
  assign tr_null = is_null[SLOT_TR];
  assign ss_null = is_null[SLOT_SS] & ~host64;
endmodule

// File: rtl/hsv_canon_check.sv
module hsv_canon_check #(
  parameter int ADDR_W   = 64,
  parameter int VA_BITS  = 48,
  parameter int NUM_BASE = 5
) (
  input  logic [NUM_BASE*ADDR_W-1:0] base,
  output logic [NUM_BASE-1:0]        bad
);
  localparam int HI_W = ADDR_W - VA_BITS + 1;

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic [HI_W-1:0] upper;
    assign upper  = base[g*ADDR_W + VA_BITS - 1 +: HI_W];
    assign bad[g] = ~((&upper) | (~|upper));
  end
endmodule

// File: rtl/hsv_classify.sv
module hsv_classify #(
  parameter int VIOL_W = 16,
  parameter int CTL_POS = 15
) (
  input  logic [VIOL_W-1:0]   viol,
  output hsv_pkg::err_class_e cls
);
  import hsv_pkg::*;

  logic [VIOL_W-1:0] host_mask;
  assign host_mask = ~(VIOL_W'(1) << CTL_POS);

  always_comb begin
    if (viol[CTL_POS])              cls = CLS_CTL;
    else if (|(viol & host_mask))   cls = CLS_HOST;
    else                            cls = CLS_NONE;
  end
endmodule

// File: rtl/hsv_entry_check.sv
module hsv_entry_check #(
  parameter int SEL_W      = 16,
  parameter int NUM_SEG    = 7,
  parameter int ADDR_W     = 64,
  parameter int VA_BITS    = 48,
  parameter int NUM_BASE   = 5,
  parameter int CTL_W      = 32,
  parameter int HOST64_BIT = 9,
  parameter int ERR_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [NUM_SEG*SEL_W-1:0]  sel_i,
  input  logic [NUM_BASE*ADDR_W-1:0] base_i,
  input  logic [CTL_W-1:0]          exit_ctl_i,
  input  logic                      long_mode_i,
  output logic                      done_o,
  output logic                      pass_o,
  output logic [ERR_W-1:0]          err_o,
  output logic [hsv_pkg::VIOL_BITS-1:0] viol_o
);
  import hsv_pkg::*;

  localparam int VW = VIOL_BITS;

  // stage 1: captured snapshot
  logic                       busy_q;
  logic [NUM_SEG*SEL_W-1:0]   sel_q;
  logic [NUM_BASE*ADDR_W-1:0] base_q;
  logic                       host64_q;
  logic                       lmode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sel_q    <= '0;
      base_q   <= '0;
      host64_q <= 1'b0;
      lmode_q  <= 1'b0;
    end else begin
      busy_q <= start_i;
      if (start_i) begin
        sel_q    <= sel_i;
        base_q   <= base_i;
        host64_q <= exit_ctl_i[HOST64_BIT];
        lmode_q  <= long_mode_i;
      end
    end
  end

  // rule evaluation
  logic [NUM_SEG-1:0]  flag_bad;
  logic                cs_null, tr_null, ss_null;
  logic [NUM_BASE-1:0] canon_bad;
  logic                ctl_bad;
  logic [VW-1:0]       viol_d;
  err_class_e          cls;
  logic [ERR_W-1:0]    code_d;

  hsv_sel_check #(
    .SEL_W  (SEL_W),
    .NUM_SEG(NUM_SEG),
    .FLAG_W (3)
  ) u_sel (
    .sel     (sel_q),
    .host64  (host64_q),
    .flag_bad(flag_bad),
    .cs_null (cs_null),
    .tr_null (tr_null),
    .ss_null (ss_null)
  );

  hsv_canon_check #(
    .ADDR_W  (ADDR_W),
    .VA_BITS (VA_BITS),
    .NUM_BASE(NUM_BASE)
  ) u_canon (
    .base(base_q),
    .bad (canon_bad)
  );

  assign ctl_bad = lmode_q & ~host64_q;

  always_comb begin
    viol_d = '0;
    viol_d[NUM_SEG-1:0] = flag_bad;
    viol_d[VB_NULL_CS]  = cs_null;
    viol_d[VB_NULL_TR]  = tr_null;
    viol_d[VB_NULL_SS]  = ss_null;
    viol_d[VB_CANON0 +: NUM_BASE] = canon_bad;
    viol_d[VB_LMODE]    = ctl_bad;
  end

  hsv_classify #(
    .VIOL_W (VW),
    .CTL_POS(VB_LMODE)
  ) u_cls (
    .viol(viol_d),
    .cls (cls)
  );

  always_comb begin
    unique case (cls)
      CLS_CTL:  code_d = ERR_W'(CODE_CTL);
      CLS_HOST: code_d = ERR_W'(CODE_HOST);
      default:  code_d = ERR_W'(CODE_NONE);
    endcase
  end

  // stage 2: registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      err_o  <= '0;
      viol_o <= '0;
    end else if (busy_q) begin
      done_o <= 1'b1;
      pass_o <= (cls == CLS_NONE);
      err_o  <= code_d;
      viol_o <= viol_d;
    end else if (start_i) begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hsv_entry_check_sva.sv
module hsv_entry_check_sva #(
  parameter int SEL_W      = 16,
  parameter int NUM_SEG    = 7,
  parameter int CTL_W      = 32,
  parameter int HOST64_BIT = 9,
  parameter int ERR_W      = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start_i,
  input logic [NUM_SEG*SEL_W-1:0] sel_i,
  input logic [CTL_W-1:0]         exit_ctl_i,
  input logic                     long_mode_i,
  input logic                     done_o,
  input logic                     pass_o,
  input logic [ERR_W-1:0]         err_o,
  input logic [15:0]              viol_o
);
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> ##1 done_o);

  assert_done_low_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !$past(start_i)) |=> !done_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ##1 ($stable(viol_o) && $stable(err_o) && $stable(pass_o)));

  assert_pass_code_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pass_o == (err_o == '0)));

  assert_ctl_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && viol_o[15]) |-> (err_o == ERR_W'(7)));

  assert_host_code_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !viol_o[15] && (viol_o[14:0] != '0)) |-> (err_o == ERR_W'(8)));

  assert_ss_waived_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && exit_ctl_i[HOST64_BIT] && (sel_i[SEL_W +: SEL_W] == '0))
      |=> ##1 !viol_o[9]);

  assert_lmode_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && long_mode_i && !exit_ctl_i[HOST64_BIT]) |=> ##1 viol_o[15]);

  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !pass_o && err_o == '0 && viol_o == '0));
endmodule

bind hsv_entry_check hsv_entry_check_sva #(
  .SEL_W     (SEL_W),
  .NUM_SEG   (NUM_SEG),
  .CTL_W     (CTL_W),
  .HOST64_BIT(HOST64_BIT),
  .ERR_W     (ERR_W)
) u_sva (.*);

// File: tb/tb_hsv_entry_check.sv
module tb_hsv_entry_check;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [111:0] sel_i;
  logic [319:0] base_i;
  logic [31:0]  exit_ctl_i;
  logic         long_mode_i;
  logic         done_o;
  logic         pass_o;
  logic [7:0]   err_o;
  logic [15:0]  viol_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hsv_entry_check dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i), .base_i(base_i),
    .exit_ctl_i(exit_ctl_i), .long_mode_i(long_mode_i),
    .done_o(done_o), .pass_o(pass_o), .err_o(err_o), .viol_o(viol_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_viol(input logic [111:0] s,
      input logic [319:0] b, input logic [31:0] c, input logic lm);
    logic [15:0] v = '0;
    for (int i = 0; i < 7; i++) if (s[i*16 +: 3] != 3'b000) v[i] = 1'b1;
    v[7] = (s[0 +: 16] == 16'h0);
    v[8] = (s[96 +: 16] == 16'h0);
    v[9] = (s[16 +: 16] == 16'h0) && !c[9];
    for (int i = 0; i < 5; i++) begin
      logic [63:0] a = b[i*64 +: 64];
      logic [63:0] ext = {{16{a[47]}}, a[47:0]};
      v[10+i] = (ext != a);
    end
    v[15] = lm && !c[9];
    return v;
  endfunction

  task automatic set_good();
    sel_i = {16'h0040, 16'h0038, 16'h0030, 16'h0028, 16'h0020, 16'h0018, 16'h0010};
    for (int i = 0; i < 5; i++) base_i[i*64 +: 64] = 64'h0000_1234_5678_9000 + 64'(i*4096);
    exit_ctl_i  = 32'h0000_0200;
    long_mode_i = 1'b1;
  endtask

  task automatic run(input string tag);
    logic [15:0] ev;
    logic [7:0]  ee;
    ev = model_viol(sel_i, base_i, exit_ctl_i, long_mode_i);
    ee = ev[15] ? 8'd7 : (ev != 0 ? 8'd8 : 8'd0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, {tag, " R8 done low"}, 16'(done_o), 16'h0);
    sel_i = ~sel_i; base_i = {10{$urandom()}}; exit_ctl_i = ~exit_ctl_i;
    long_mode_i = ~long_mode_i;
    @(negedge clk);
    check(done_o == 1'b1, {tag, " R8 done"}, 16'(done_o), 16'h1);
    check(viol_o == ev, {tag, " map"}, viol_o, ev);
    check(err_o == ee, {tag, " R6 R7 code"}, 16'(err_o), 16'(ee));
    check(pass_o == (ee == 0), {tag, " R7 pass"}, 16'(pass_o), 16'(ee == 0));
    repeat (2) @(negedge clk);
    check(viol_o == ev && err_o == ee && done_o, {tag, " R8 hold"}, viol_o, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start_i = 1'b0;
    set_good();
    repeat (3) @(negedge clk);
    check(!done_o && !pass_o && err_o == 0 && viol_o == 0, "R9 reset", viol_o, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    set_good(); run("R7 clean");
    for (int i = 0; i < 7; i++) begin
      set_good(); sel_i[i*16 +: 3] = 3'(1 << (i % 3)); run("R1 flag");
    end
    set_good(); sel_i[0 +: 16] = 16'h0; run("R2 cs null");
    set_good(); sel_i[96 +: 16] = 16'h0; run("R2 tr null");
    set_good(); sel_i[32 +: 16] = 16'h0; run("R2 ds null allowed");
    set_good(); sel_i[16 +: 16] = 16'h0; run("R3 ss null waived");
    set_good(); sel_i[16 +: 16] = 16'h0; exit_ctl_i = 32'h0; long_mode_i = 1'b0;
    run("R3 ss null flagged");
    set_good(); exit_ctl_i = 32'hFFFF_FDFF; long_mode_i = 1'b0; run("R5 lm off ok");
    set_good(); exit_ctl_i = 32'h0; run("R5 lm ctl");
    for (int i = 0; i < 5; i++) begin
      set_good(); base_i[i*64 +: 64] = 64'h0000_8000_0000_0000; run("R4 noncanon");
      set_good(); base_i[i*64 +: 64] = 64'hFFFF_8000_0000_0000; run("R4 canon high");
      set_good(); base_i[i*64 +: 64] = 64'h0000_7FFF_FFFF_FFFF; run("R4 canon edge");
    end
    set_good(); exit_ctl_i = 32'h0; sel_i[80 +: 3] = 3'b011;
    base_i[128 +: 64] = 64'h1000_0000_0000_0000; run("R6 ctl over host");

    // back-to-back starts
    set_good(); sel_i[0 +: 16] = 16'h0; start_i = 1'b1; @(negedge clk);
    set_good(); @(negedge clk); start_i = 1'b0;
    check(done_o && viol_o == 16'h0080, "R8 b2b first", viol_o, 16'h0080);
    @(negedge clk);
    check(done_o && viol_o == 16'h0000 && err_o == 0, "R8 b2b second", viol_o, 16'h0);

    for (int k = 0; k < 300; k++) begin
      set_good();
      for (int i = 0; i < 7; i++) begin
        int r = $urandom_range(0, 9);
        if (r == 0) sel_i[i*16 +: 16] = 16'h0;
        else if (r < 3) sel_i[i*16 +: 16] = 16'($urandom());
        else sel_i[i*16 +: 16] = 16'($urandom()) & 16'hFFF8;
      end
      for (int i = 0; i < 5; i++) begin
        int r = $urandom_range(0, 5);
        logic [63:0] a = {$urandom(), $urandom()};
        if (r == 0) base_i[i*64 +: 64] = a;
        else base_i[i*64 +: 64] = {{16{a[47]}}, a[47:0]};
      end
      exit_ctl_i  = $urandom();
      long_mode_i = 1'($urandom());
      run("R1 R2 R3 R4 R5 random");
    end

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(!done_o && viol_o == 0 && err_o == 0 && !pass_o, "R9 late reset", viol_o, 16'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule